// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds the return addresses of a small processor core. Each time the core executes a subroutine call or accepts an interrupt, it strobes `pushEn` and presents the current program counter on `pushData`. Each time it executes a return-type instruction, it strobes `popEn` and, one cycle later, takes the return address from `popData`. The storage is sixteen words of sixteen bits. It sits outside both program and data memory. A four-bit pointer that software can neither read nor write addresses it.

The pointer never saturates. Pushing past the last slot wraps to slot zero and overwrites the oldest return address. Popping below slot zero wraps to slot fifteen. The only status is `stackAvail`. It drops while the pointer sits at its highest value. Once a push carries the pointer from the highest value back to zero, it stays low until the next reset. An underflowing pop also parks the pointer at the highest value, so it reads the same as a full stack.

Top module: `ret_addr_stack`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the pointer to slot 0 and drives `stackAvail` to 1.
- R2: A push stores `pushData` in the slot the pointer names and then advances the pointer by one, modulo 16.
- R3: A pop moves the pointer back by one, modulo 16. From the cycle after the pop strobe, `popData` shows the slot the pointer now names, so the most recent unpopped push comes back first.
- R4: With no pop in between, push 17 overwrites the slot written by push 1 and push 18 overwrites push 2. After 17 pushes, 16 pops return pushes 17 down to 2, and a 17th pop returns push 17 again.
- R5: While the lock is clear, `stackAvail` is 0 exactly when the pointer holds 15. It is 1 for every other pointer value, so a pop from 15 to 14 raises it again.
- R6: A push made while the pointer holds 15 sets a lock. From then on `stackAvail` stays 0 whatever pushes or pops follow, until a reset.
- R7: A pop taken straight after reset wraps the pointer to 15 and lowers `stackAvail` without setting the lock. A push that follows before any other pop sets the lock (R6).
- R8: When `pushEn` and `popEn` are both high in one cycle, only the push takes effect: the data is stored and the pointer advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pushEn | input | 1 | Push strobe (call or interrupt accept) |
| pushData | input | 16 | Return address to store |
| popEn | input | 1 | Pop strobe (return-type instruction) |
| popData | output | 16 | Slot named by the pointer; return address after a pop |
| stackAvail | output | 1 | Stack-available status, sticky low after a wrap |

## Verification
The bench goes after the wrap points. It does a 17th push and checks that a design that refuses to overwrite, or saturates the pointer, returns the wrong addresses on the pops that follow. It pops straight out of reset, then pops again and pushes. A design that sets the lock on a downward wrap, or never re-raises the flag from 14, shows the wrong `stackAvail`. A design that misses the lock on the upward wrap raises the flag again later. Simultaneous push and pop strobes catch a design that lets the pop win or applies both.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

  // Strobes from control to datapath for one clock cycle.
  typedef struct packed {
    logic wrSlot;   // capture pushData into the addressed slot
    logic ptrUp;    // advance pointer
    logic ptrDown;  // retreat pointer
  } stackStrobe_t;

endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import ret_stack_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushEn,
  input  logic             popEn,
  input  logic [PTR_W-1:0] ptr,
  output stackStrobe_t     strb,
  output logic             stackAvail
);

  localparam logic [PTR_W-1:0] TOP_SLOT = '1;

  logic             lockQ;
  logic             lockNext;
  logic             availNext;
  logic [PTR_W-1:0] ptrNext;

  // Push wins over pop.
  always_comb begin
    strb.wrSlot  = pushEn;
    strb.ptrUp   = pushEn;
    strb.ptrDown = popEn && !pushEn;
  end

  always_comb begin
    if (strb.ptrUp)        ptrNext = ptr + PTR_W'(1);
    else if (strb.ptrDown) ptrNext = ptr - PTR_W'(1);
    else                   ptrNext = ptr;
  end

  // The lock sets only on the upward wrap from the top slot to zero.
  assign lockNext  = lockQ || (strb.ptrUp && (ptr == TOP_SLOT));
  assign availNext = !lockNext && (ptrNext != TOP_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      lockQ      <= 1'b0;
      stackAvail <= 1'b1;
    end else begin
      lockQ      <= lockNext;
      stackAvail <= availNext;
    end
  end

endmodule

// File: rtl/ret_stack_dp.sv
module ret_stack_dp
  import ret_stack_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  stackStrobe_t     strb,
  input  logic [WIDTH-1:0] pushData,
  output logic [PTR_W-1:0] ptr,
  output logic [WIDTH-1:0] popData
);

  logic [WIDTH-1:0] slotQ [DEPTH];

  always_ff @(posedge clk) begin
    if (rst)               ptr <= '0;
    else if (strb.ptrUp)   ptr <= ptr + PTR_W'(1);
    else if (strb.ptrDown) ptr <= ptr - PTR_W'(1);
  end

  // One register per slot, written only when addressed.
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strb.wrSlot && (ptr == PTR_W'(g))) slotQ[g] <= pushData;
    end
  end

  assign popData = slotQ[ptr];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] popData,
  output logic             stackAvail
);

  localparam int PTR_W = $clog2(DEPTH);

  stackStrobe_t     strb;
  logic [PTR_W-1:0] stackPtr;

  ret_stack_ctrl #(.PTR_W(PTR_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .pushEn     (pushEn),
    .popEn      (popEn),
    .ptr        (stackPtr),
    .strb       (strb),
    .stackAvail (stackAvail)
  );

  ret_stack_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PTR_W(PTR_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .pushData (pushData),
    .ptr      (stackPtr),
    .popData  (popData)
  );

endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pushEn,
  input logic             popEn,
  input logic             stackAvail,
  input logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] TOP_SLOT = '1;

  AST_RESET_AVAIL: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (stackAvail && ptr == '0)); // R1

  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (pushEn && !popEn) |=> (ptr == PTR_W'($past(ptr) + PTR_W'(1)))); // R2

  AST_POP_RETREAT: assert property (@(posedge clk) disable iff (rst)
    (popEn && !pushEn) |=> (ptr == PTR_W'($past(ptr) - PTR_W'(1)))); // R3

  AST_TOP_NOT_AVAIL: assert property (@(posedge clk) disable iff (rst)
    (ptr == TOP_SLOT) |-> !stackAvail); // R5

  AST_WRAP_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (pushEn && ptr == TOP_SLOT) |=> !stackAvail); // R6

  AST_PUSH_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (pushEn && popEn) |=> (ptr == PTR_W'($past(ptr) + PTR_W'(1)))); // R8

endmodule

bind ret_addr_stack ret_addr_stack_chk #(.PTR_W(PTR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .pushEn     (pushEn),
  .popEn      (popEn),
  .stackAvail (stackAvail),
  .ptr        (stackPtr)
);

// File: tb/ret_addr_stack_tb_top.sv
`timescale 1ns/1ps
module ret_addr_stack_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pushEn = 1'b0;
  logic        popEn = 1'b0;
  logic [15:0] pushData = '0;
  logic [15:0] popData;
  logic        stackAvail;

  int checks = 0;
  int fails  = 0;

  // Reference state built from the requirements.
  logic [15:0] mMem [16];
  bit          mValid [16];
  int          mPtr;
  bit          mLock;

  // Scoreboard of expected pop results.
  logic [15:0] expData [$];
  bit          expKnown [$];
  string       expTag [$];

  always #2.5 clk = ~clk;

  ret_addr_stack dut_i (
    .clk(clk), .rst(rst), .pushEn(pushEn), .pushData(pushData),
    .popEn(popEn), .popData(popData), .stackAvail(stackAvail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit expAvail();
    return !mLock && (mPtr != 15);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; pushEn = 1'b0; popEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    mPtr = 0; mLock = 1'b0;
    for (int i = 0; i < 16; i++) mValid[i] = 1'b0;
    check(stackAvail == 1'b1, "R1", int'(stackAvail), 1);
  endtask

  // One operation, then an idle input state; avail checked afterwards.
  task automatic doOp(input bit doPush, input bit doPop, input logic [15:0] d, input string req);
    @(negedge clk);
    pushEn = doPush; popEn = doPop; pushData = d;
    if (doPush) begin
      if (mPtr == 15) mLock = 1'b1;
      mMem[mPtr] = d; mValid[mPtr] = 1'b1;
      mPtr = (mPtr + 1) % 16;
    end else if (doPop) begin
      mPtr = (mPtr + 15) % 16;
      expData.push_back(mMem[mPtr]);
      expKnown.push_back(mValid[mPtr]);
      expTag.push_back(req);
    end
    @(negedge clk);
    pushEn = 1'b0; popEn = 1'b0;
    check(stackAvail == expAvail(), req, int'(stackAvail), int'(expAvail()));
  endtask

  // Monitor: compare pop data in the cycle after the pop strobe.
  initial begin
    forever begin
      @(posedge clk);
      begin
        bit sawPop;
        sawPop = popEn && !pushEn && !rst;
        #1;
        if (sawPop && expData.size() > 0) begin
          logic [15:0] e;
          bit k;
          string t;
          e = expData.pop_front(); k = expKnown.pop_front(); t = expTag.pop_front();
          if (k) check(popData == e, t, int'(popData), int'(e));
        end
      end
    end
  end

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset();                                   // R1
    // R2/R3: LIFO order
    doOp(1, 0, 16'h1A00, "R2");
    doOp(1, 0, 16'h2B11, "R2");
    doOp(1, 0, 16'h3C22, "R2");
    doOp(0, 1, 16'h0000, "R3");
    doOp(0, 1, 16'h0000, "R3");
    doOp(0, 1, 16'h0000, "R3");
    // R8: push wins when both strobes are high
    doOp(1, 0, 16'h4D33, "R8");
    doOp(1, 1, 16'h5E44, "R8");
    doOp(0, 1, 16'h0000, "R8");
    doOp(0, 1, 16'h0000, "R8");

    // R7: underflow then recovery, then lock via push
    doReset();
    doOp(0, 1, 16'h0000, "R7");                  // ptr 15, avail 0, no lock
    doOp(0, 1, 16'h0000, "R7");                  // ptr 14, avail 1
    doOp(1, 0, 16'h6F55, "R5");                  // ptr 15, avail 0
    doOp(1, 0, 16'h7066, "R6");                  // wrap to 0, lock
    doOp(0, 1, 16'h0000, "R6");                  // ptr 15
    doOp(0, 1, 16'h0000, "R6");                  // ptr 14, still locked
    doOp(0, 1, 16'h0000, "R6");

    // R7: pop straight after reset then push locks
    doReset();
    doOp(0, 1, 16'h0000, "R7");
    doOp(1, 0, 16'h8177, "R7");
    doOp(1, 0, 16'h9288, "R6");
    doOp(0, 1, 16'h0000, "R6");
    doOp(0, 1, 16'h0000, "R6");

    // R4/R5: fill, overwrite, drain
    doReset();
    for (int i = 0; i < 17; i++) doOp(1, 0, 16'hA000 + 16'(i * 3), (i == 14) ? "R5" : "R4");
    for (int i = 0; i < 17; i++) doOp(0, 1, 16'h0000, "R4");

    // R1: reset clears lock
    doReset();
    doOp(1, 0, 16'hBEEF, "R1");
    doOp(0, 1, 16'h0000, "R1");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule